// File: doc/BRIEF.md
# Triggered Compare-and-Clear Unit

This unit sits next to a free-running event counter and decides when that counter should be zeroed. At chosen evaluation moments it compares the live counter value with a threshold word and, when the comparison holds, emits a one-cycle clear strobe and latches a sticky match flag. Evaluation moments come either from a prescaled sample-clock tick or from edges of an external trigger line. The same trigger line can also hold the counter still while it sits at its active level.

The threshold word can be read three ways: as an upper bound, as a lower bound, or as a window whose lower limit is the low half of the word and whose upper limit is the high half. One polarity bit sets both which trigger edge starts an evaluation and which trigger level holds the counter. Configuration is captured from a set of input fields on a load strobe and comes out of reset in a harmless state.

Top module: `cmpclr_unit`

## Requirements
- R1: After reset the configuration is mode disabled, divide-by-1, less-or-equal compare, polarity 0 and gating off, and clr_o, match_o and gate_o are all 0.
- R2: Mode code 0 disables evaluation and mode code 3 behaves the same: no clear strobe is produced whatever tick_i and trig_i do.
- R3: In mode code 1 an evaluation happens on every 2^cfg_presc_i-th asserted tick_i (prescale codes 0..3 give 1, 2, 4, 8); ticks are counted only in this mode, and any configuration load restarts the tick count.
- R4: Compare code 0 matches when cnt_i <= top_i.
- R5: Compare code 1 matches when cnt_i >= top_i.
- R6: Compare code 2 matches when cnt_i >= top_i[7:0] and cnt_i <= top_i[15:8]; compare code 3 never matches.
- R7: In mode code 2 an evaluation happens when trig_i differs from its value at the previous clock edge: a 0-to-1 change with polarity 0, a 1-to-0 change with polarity 1.
- R8: An evaluation that matches drives clr_o high for exactly the cycle after the clock edge at which it was seen; each evaluation gives at most one such cycle.
- R9: match_o becomes 1 together with clr_o and stays 1 until flag_clr_i is seen at a clock edge with no new match; a match at the same edge wins over the clear.
- R10: gate_o is 1 when gating is enabled and trig_i is at its active level (high for polarity 0, low for polarity 1), follows trig_i in the same cycle, and does not depend on the mode.
- R11: Configuration fields are captured at a clock edge where cfg_we_i is 1 and govern evaluation from the next edge on; an evaluation at the load edge uses the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | 16 | Current value of the external counter |
| top_i | input | 16 | Threshold word (window limits in its two bytes) |
| tick_i | input | 1 | Sample-clock tick qualifier |
| trig_i | input | 1 | External trigger line |
| cfg_we_i | input | 1 | Load strobe for the configuration fields |
| cfg_mode_i | input | 2 | 0 off, 1 tick evaluation, 2 trigger evaluation, 3 off |
| cfg_presc_i | input | 2 | Tick divide code, divisor 2^code |
| cfg_cmp_i | input | 2 | 0 less-or-equal, 1 greater-or-equal, 2 window, 3 never |
| cfg_pol_i | input | 1 | Trigger polarity for edge and gating level |
| cfg_gate_en_i | input | 1 | Enables holding the counter from the trigger line |
| flag_clr_i | input | 1 | Clears the sticky match flag |
| clr_o | output | 1 | One-cycle strobe that zeroes the counter |
| match_o | output | 1 | Sticky match flag |
| gate_o | output | 1 | 1 while the counter must not count |

## Verification
An evaluation seen at clock edge N shows on clr_o and match_o after edge N, so the bench samples them at the falling edge that follows, while gate_o is combinational on trig_i and the stored polarity and is sampled in the same half cycle as the trigger change. A behavioural model advances at each rising edge from the inputs the bench drove a half cycle earlier and is compared at every falling edge, before new inputs are applied. The modelled counter also updates at falling edges, so cnt_i never moves near the edge at which the unit compares it.

// File: rtl/cmpclr_pkg.sv
package cmpclr_pkg;

    localparam int PSC_W = 2;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_TICK = 2'd1,
        MODE_TRIG = 2'd2,
        MODE_RSVD = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        CMP_LE   = 2'd0,
        CMP_GE   = 2'd1,
        CMP_WIN  = 2'd2,
        CMP_NONE = 2'd3
    } cmp_e;

    typedef struct packed {
        mode_e            mode;
        logic [PSC_W-1:0] presc;
        cmp_e             cmp;
        logic             pol;
        logic             gate_en;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{
        mode:    MODE_OFF,
        presc:   '0,
        cmp:     CMP_LE,
        pol:     1'b0,
        gate_en: 1'b0
    };

endpackage

// File: rtl/cmpclr_presc.sv
module cmpclr_presc #(
    parameter int PSC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic             restart_i,
    input  logic [PSC_W-1:0] presc_i,
    output logic             fire_o
);
    localparam int DIV_W = (1 << PSC_W) - 1;

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } st_t;

    st_t              st_q, st_d;
    logic [DIV_W-1:0] mask;

    always_comb begin
        mask   = DIV_W'((1 << presc_i) - 1);
        fire_o = run_i && tick_i && ((st_q.cnt & mask) == mask);
        st_d   = st_q;
        if (restart_i) begin
            st_d.cnt = '0;
        end else if (run_i && tick_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3: at divide-by-1 every tick in tick mode is an evaluation
    p_div1_each_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tick_i && presc_i == '0) |-> fire_o);

    // R3: the count restarts at a load, so the first tick after it fires only at divide-by-1
    p_restart_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_i && !run_i) |=> ((run_i && tick_i && presc_i != '0) |-> !fire_o));

endmodule

// File: rtl/cmpclr_trig.sv
module cmpclr_trig (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    input  logic pol_i,
    input  logic gate_en_i,
    output logic edge_o,
    output logic gate_o
);
    typedef struct packed {
        logic prev;
    } st_t;

    st_t st_q, st_d;

    always_comb begin
        st_d.prev = trig_i;
        if (pol_i) begin
            edge_o = st_q.prev && !trig_i;
        end else begin
            edge_o = !st_q.prev && trig_i;
        end
        gate_o = gate_en_i && (trig_i ^ pol_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R7: a detected edge always leaves the line at the level opposite to the polarity bit
    p_edge_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |-> (trig_i == !pol_i));

    // R7: an edge needs the line to have moved since the last clock edge
    p_edge_moved_r7: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> ($past(trig_i) != $past(trig_i, 2)));

endmodule

// File: rtl/cmpclr_cmp.sv
module cmpclr_cmp
    import cmpclr_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic [CW-1:0] cnt_i,
    input  logic [CW-1:0] top_i,
    input  cmp_e          cmp_i,
    output logic          hit_o
);
    localparam int HW = CW / 2;

    logic [CW-1:0] win_lo, win_hi;

    always_comb begin
        win_lo = {{(CW - HW){1'b0}}, top_i[HW-1:0]};
        win_hi = {{HW{1'b0}}, top_i[CW-1:HW]};
        unique case (cmp_i)
            CMP_LE:  hit_o = cnt_i <= top_i;
            CMP_GE:  hit_o = cnt_i >= top_i;
            CMP_WIN: hit_o = (cnt_i >= win_lo) && (cnt_i <= win_hi);
            default: hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/cmpclr_unit.sv
module cmpclr_unit
    import cmpclr_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CW-1:0]    cnt_i,
    input  logic [CW-1:0]    top_i,
    input  logic             tick_i,
    input  logic             trig_i,
    input  logic             cfg_we_i,
    input  logic [1:0]       cfg_mode_i,
    input  logic [PSC_W-1:0] cfg_presc_i,
    input  logic [1:0]       cfg_cmp_i,
    input  logic             cfg_pol_i,
    input  logic             cfg_gate_en_i,
    input  logic             flag_clr_i,
    output logic             clr_o,
    output logic             match_o,
    output logic             gate_o
);
    typedef struct packed {
        cfg_t cfg;
        logic clr;
        logic flag;
    } st_t;

    st_t  st_q, st_d;
    cfg_t cfg_in;
    logic fire, trig_edge, hit, eval;

    cmpclr_presc #(.PSC_W(PSC_W)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (st_q.cfg.mode == MODE_TICK),
        .tick_i    (tick_i),
        .restart_i (cfg_we_i),
        .presc_i   (st_q.cfg.presc),
        .fire_o    (fire)
    );

    cmpclr_trig u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_i    (trig_i),
        .pol_i     (st_q.cfg.pol),
        .gate_en_i (st_q.cfg.gate_en),
        .edge_o    (trig_edge),
        .gate_o    (gate_o)
    );

    cmpclr_cmp #(.CW(CW)) u_cmp (
        .cnt_i (cnt_i),
        .top_i (top_i),
        .cmp_i (st_q.cfg.cmp),
        .hit_o (hit)
    );

    always_comb begin
        cfg_in = '{
            mode:    mode_e'(cfg_mode_i),
            presc:   cfg_presc_i,
            cmp:     cmp_e'(cfg_cmp_i),
            pol:     cfg_pol_i,
            gate_en: cfg_gate_en_i
        };
        unique case (st_q.cfg.mode)
            MODE_TICK: eval = fire;
            MODE_TRIG: eval = trig_edge;
            default:   eval = 1'b0;
        endcase

        st_d     = st_q;
        st_d.clr = eval && hit;
        if (eval && hit) begin
            st_d.flag = 1'b1;
        end else if (flag_clr_i) begin
            st_d.flag = 1'b0;
        end
        if (cfg_we_i) begin
            st_d.cfg = cfg_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cfg: CFG_RESET, clr: 1'b0, flag: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign clr_o   = st_q.clr;
    assign match_o = st_q.flag;

    // R2: with evaluation switched off no strobe follows
    p_off_no_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cfg.mode == MODE_OFF || st_q.cfg.mode == MODE_RSVD) |=> !clr_o);

    // R9: a strobe is always accompanied by the flag
    p_clr_has_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_o |-> match_o);

    // R9: the flag only drops on a software clear
    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (match_o && !flag_clr_i) |=> match_o);

    // R8: the flag can only rise together with a strobe
    p_flag_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match_o) |-> clr_o);

    // R10: gating never asserted while disabled in the stored configuration
    p_gate_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.cfg.gate_en |-> !gate_o);

endmodule

// File: tb/cmpclr_unit_bench.sv
`timescale 1ns/1ps
module cmpclr_unit_bench;

    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] cnt = '0;
    logic [CW-1:0] top = '0;
    logic          tick = 1'b0, trig = 1'b0, inc = 1'b0, fclr = 1'b0, we = 1'b0;
    logic [1:0]    c_mode = '0, c_presc = '0, c_cmp = '0;
    logic          c_pol = 1'b0, c_gen = 1'b0;
    logic          clr_o, match_o, gate_o;

    int    n_tests = 0;
    int    n_fail  = 0;
    int    nclr    = 0;
    bit    done    = 1'b0;
    string cur_req = "R1";

    // behavioural model state
    int   m_mode = 0, m_presc = 0, m_cmp = 0, m_tc = 0;
    logic m_pol = 1'b0, m_gen = 1'b0, m_prev = 1'b0, m_clr = 1'b0, m_flag = 1'b0;

    always #2 clk = ~clk;

    cmpclr_unit #(.CW(CW)) u_cmpclr_unit (
        .clk           (clk),
        .rst_n         (rst_n),
        .cnt_i         (cnt),
        .top_i         (top),
        .tick_i        (tick),
        .trig_i        (trig),
        .cfg_we_i      (we),
        .cfg_mode_i    (c_mode),
        .cfg_presc_i   (c_presc),
        .cfg_cmp_i     (c_cmp),
        .cfg_pol_i     (c_pol),
        .cfg_gate_en_i (c_gen),
        .flag_clr_i    (fclr),
        .clr_o         (clr_o),
        .match_o       (match_o),
        .gate_o        (gate_o)
    );

    function automatic bit model_hit(int cmp, int c, int t);
        int lo, hi;
        lo = t % 256;
        hi = t / 256;
        case (cmp)
            0: return c <= t;
            1: return c >= t;
            2: return (c >= lo) && (c <= hi);
            default: return 1'b0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_presc = 0; m_cmp = 0; m_pol = 0; m_gen = 0;
            m_tc = 0; m_prev = 0; m_clr = 0; m_flag = 0;
        end else begin
            bit ev;
            ev = 1'b0;
            if (m_mode == 1 && tick && ((m_tc + 1) % (1 << m_presc)) == 0) ev = 1'b1;
            if (m_mode == 2) ev = m_pol ? (m_prev && !trig) : (!m_prev && trig);
            m_clr = ev && model_hit(m_cmp, int'(cnt), int'(top));
            if (m_clr) m_flag = 1'b1;
            else if (fclr) m_flag = 1'b0;
            if (we) m_tc = 0;
            else if (m_mode == 1 && tick) m_tc = m_tc + 1;
            m_prev = trig;
            if (we) begin
                m_mode = c_mode; m_presc = c_presc; m_cmp = c_cmp;
                m_pol = c_pol; m_gen = c_gen;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // per-cycle comparison against the model, then the modelled counter moves
    always @(negedge clk) begin
        if (rst_n) begin
            logic g_exp;
            g_exp = m_gen && (trig ^ m_pol);
            chk(clr_o === m_clr, {cur_req, " R8 clr_o"}, int'(clr_o), int'(m_clr));
            chk(match_o === m_flag, {cur_req, " R9 match_o"}, int'(match_o), int'(m_flag));
            chk(gate_o === g_exp, {cur_req, " R10 gate_o"}, int'(gate_o), int'(g_exp));
            if (clr_o) nclr++;
            if (m_clr) cnt <= '0;
            else if (inc && !g_exp) cnt <= cnt + 1'b1;
        end
    end

    task automatic cyc(input logic t, input logic g, input logic i, input logic f = 1'b0);
        @(negedge clk); #1;
        tick = t; trig = g; inc = i; fclr = f; we = 1'b0;
    endtask

    task automatic load(input int md, input int ps, input int cm, input logic pl, input logic ge);
        @(negedge clk); #1;
        c_mode = 2'(md); c_presc = 2'(ps); c_cmp = 2'(cm); c_pol = pl; c_gen = ge;
        we = 1'b1; tick = 1'b0; fclr = 1'b0;
    endtask

    task automatic look;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int n0;
        int hold;
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state, default config disabled and not gating
        look;
        chk(clr_o == 0 && match_o == 0 && gate_o == 0, "R1 reset outputs", {clr_o, match_o, gate_o}, 0);
        n0 = nclr;
        for (int k = 0; k < 10; k++) cyc(1'b1, k[0], 1'b1);
        cyc(1'b0, 1'b0, 1'b0);
        chk(nclr == n0 && gate_o == 0, "R1 default idle", nclr - n0, 0);

        // R2: reserved mode code 3 does nothing
        cur_req = "R2"; top = 16'hFFFF;
        load(3, 0, 0, 0, 0); n0 = nclr;
        for (int k = 0; k < 20; k++) cyc(1'b1, k[1], 1'b1);
        cyc(1'b0, 1'b0, 1'b0);
        chk(nclr == n0, "R2 mode3 clears", nclr - n0, 0);

        // R3: divide-by-4, 16 ticks -> 4 evaluations, all matching
        cur_req = "R3";
        load(1, 2, 0, 0, 0); n0 = nclr;
        for (int k = 0; k < 16; k++) cyc(1'b1, 1'b0, 1'b0);
        repeat (3) cyc(1'b0, 1'b0, 1'b0);
        chk(nclr - n0 == 4, "R3 div4 count", nclr - n0, 4);
        load(1, 3, 0, 0, 0); n0 = nclr;
        for (int k = 0; k < 16; k++) cyc(k[0], 1'b0, 1'b0);
        repeat (3) cyc(1'b0, 1'b0, 1'b0);
        chk(nclr - n0 == 1, "R3 div8 sparse ticks", nclr - n0, 1);

        // R4: less-or-equal with a small threshold
        cur_req = "R4"; top = 16'd3;
        load(1, 0, 0, 0, 0);
        for (int k = 0; k < 20; k++) cyc(k % 3 == 0, 1'b0, 1'b1);

        // R5: greater-or-equal, divide-by-2
        cur_req = "R5"; top = 16'd5;
        load(1, 1, 1, 0, 0); n0 = nclr;
        for (int k = 0; k < 30; k++) cyc(1'b1, 1'b0, 1'b1);
        chk(nclr - n0 > 0, "R5 ge clears seen", nclr - n0, 1);

        // R6: never-match code lets the counter climb
        cur_req = "R6";
        load(1, 0, 3, 0, 0); n0 = nclr;
        for (int k = 0; k < 24; k++) cyc(1'b1, 1'b0, 1'b1);
        cyc(1'b1, 1'b0, 1'b0);
        chk(nclr == n0 && cnt >= 16'd20, "R6 code3 never", nclr - n0, 0);
        // window 4..10 with counter above it: no match
        top = 16'h0A04;
        load(1, 0, 2, 0, 0); n0 = nclr;
        for (int k = 0; k < 8; k++) cyc(1'b1, 1'b0, 1'b0);
        chk(nclr == n0, "R6 above window", nclr - n0, 0);
        // window 4..30 covers it
        top = 16'h1E04; n0 = nclr;
        cyc(1'b1, 1'b0, 1'b0); cyc(1'b0, 1'b0, 1'b0); cyc(1'b0, 1'b0, 1'b0);
        chk(nclr - n0 == 1, "R6 inside window", nclr - n0, 1);
        // counter from 0 upward: below lower bound at first
        for (int k = 0; k < 12; k++) cyc(1'b1, 1'b0, 1'b1);

        // R7: rising edges with polarity 0
        cur_req = "R7"; top = 16'hFFFF;
        load(2, 0, 0, 0, 0); n0 = nclr;
        for (int k = 0; k < 5; k++) begin cyc(1'b0, 1'b1, 1'b0); cyc(1'b0, 1'b0, 1'b0); end
        cyc(1'b0, 1'b0, 1'b0);
        chk(nclr - n0 == 5, "R7 rising pol0", nclr - n0, 5);
        load(2, 0, 0, 1, 0); n0 = nclr;
        for (int k = 0; k < 5; k++) begin cyc(1'b0, 1'b1, 1'b0); cyc(1'b0, 1'b0, 1'b0); end
        cyc(1'b0, 1'b0, 1'b0);
        chk(nclr - n0 == 5, "R7 falling pol1", nclr - n0, 5);

        // R8: strobe lasts one cycle while trigger stays high
        cur_req = "R8";
        load(2, 0, 0, 0, 0);
        cyc(1'b0, 1'b0, 1'b0);
        cyc(1'b0, 1'b1, 1'b0);
        look; chk(clr_o == 1, "R8 strobe on", clr_o, 1);
        look; chk(clr_o == 0, "R8 strobe off", clr_o, 0);

        // R9: software clear of flag, and set winning over clear
        cur_req = "R9";
        cyc(1'b0, 1'b1, 1'b0, 1'b1);
        look; chk(match_o == 0, "R9 flag cleared", match_o, 0);
        cyc(1'b0, 1'b0, 1'b0);
        cyc(1'b0, 1'b1, 1'b0, 1'b1);
        look; chk(match_o == 1, "R9 set beats clear", match_o, 1);

        // R10: gating with mode off, both polarities
        cur_req = "R10";
        load(0, 0, 0, 0, 1);
        cyc(1'b0, 1'b1, 1'b1);
        look; chk(gate_o == 1, "R10 pol0 high gates", gate_o, 1);
        hold = int'(cnt);
        repeat (5) cyc(1'b0, 1'b1, 1'b1);
        chk(int'(cnt) == hold, "R10 counter held", int'(cnt), hold);
        load(0, 0, 0, 1, 1);
        cyc(1'b0, 1'b0, 1'b1);
        look; chk(gate_o == 1, "R10 pol1 low gates", gate_o, 1);
        cyc(1'b0, 1'b1, 1'b1);
        look; chk(gate_o == 0, "R10 pol1 high free", gate_o, 0);

        // R11: random traffic with configuration reloads
        cur_req = "R11 random";
        for (int k = 0; k < 4000; k++) begin
            if ($urandom % 40 == 0) begin
                top = 16'({$urandom % 40, $urandom % 24});
                if ($urandom % 2 == 0) top = 16'($urandom % 40);
                load($urandom % 4, $urandom % 4, $urandom % 4, 1'($urandom), 1'($urandom));
            end else begin
                cyc(1'($urandom), ($urandom % 3 == 0) ? ~trig : trig,
                    ($urandom % 4 != 0), ($urandom % 20 == 0));
            end
        end
        cyc(1'b0, trig, 1'b0);
        look;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule